// File: doc/BRIEF.md
# PLL Frequency Change Sequencer

This block moves a system clock from one PLL setting to another without ever running logic on an unlocked PLL. A request carries the new multiplier and divider, the wait-state count and voltage mode the memory and core need at the new frequency, a bus prescaler value and a set of peripheral divider values. The sequencer first moves the system clock onto the safe reference clock and waits for the glitch-free mux to confirm the switch. It then writes the new PLL setting and waits for lock, or for a fixed settle count when the request asks for timed mode.

The order of the remaining steps depends on the direction of the change. The new ratio is compared with the programmed one when the request is accepted. When the clock rises, the wait states and the voltage mode go up before the clock returns to the PLL. When it falls, the clock returns to the PLL first and the wait states and voltage mode come down afterwards. The peripheral dividers and the final bus prescaler are loaded only once the system runs on the PLL again. If lock never arrives, the system stays on the safe clock, the earlier wait states, voltage mode and bus prescaler are restored, and an error flag is set.

Top module: `clk_reseq_top`

## Requirements
- R1: After reset: `clk_sel`=1 (PLL), `pll_mul`=RST_MUL, `pll_div`=RST_DIV, `ws`=RST_WS, `vmode`=0, `bus_pre`=RST_BUS, `pdiv`=0, and `busy`, `done`, `err` and `pll_load` are all 0.
- R2: A request with `req_valid`=1 while `busy`=0 is accepted. In the next cycle `busy`=1 and `clk_sel`=0 (safe clock). A request presented while `busy`=1 is ignored and does not change the outcome of the running sequence.
- R3: `pll_load` pulses with the new `pll_mul`/`pll_div` only after `mux_src` reports 0 (safe clock). It never pulses while `mux_src`=1.
- R4: In lock mode, after `pll_load` the sequencer waits for `pll_lock`. A lock seen in the last cycle of the LOCK_TMO-cycle window counts as success.
- R5: If `pll_lock` is not seen within LOCK_TMO cycles, the sequence ends with `err`=1, `done`=0, `busy`=0 and `clk_sel` left at 0. `ws`, `vmode` and `bus_pre` return to their values from before the request.
- R6: With `req_timed`=1, the sequencer proceeds after LOCK_TIME cycles and ignores `pll_lock`.
- R7: The direction is "up" when req_mul*cur_div >= cur_mul*req_div, where cur_* are the `pll_mul`/`pll_div` values at acceptance. An equal ratio counts as up.
- R8: Up: `ws` and `vmode` take their new values before `clk_sel` returns to 1. `clk_sel` returns only after `volt_ack` equals `vmode`.
- R9: Down: `clk_sel` returns to 1 while `ws` and `vmode` still hold their old values. They change only after `mux_src`=1.
- R10: `pdiv` (NP fields of PW bits, field 0 in the low bits) changes only while `mux_src`=1, at the end of a successful sequence.
- R11: While `busy`=1, `bus_pre` is the larger of its old value and `req_bus`. On success it ends equal to `req_bus`.
- R12: `done` is a one-cycle pulse in the cycle `busy` falls after success. `err` clears when the next request is accepted.
- R13: Each handshake step (mux to safe, mux to PLL, voltage ready) holds its state until `mux_src` or `volt_ack` matches the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mul | input | MUL_W | New PLL multiplier |
| req_div | input | DIV_W | New PLL divider |
| req_ws | input | WS_W | Target memory wait states |
| req_vmode | input | 1 | Target voltage mode (1 = high) |
| req_bus | input | BUS_W | Target bus prescaler |
| req_pdiv | input | NP*PW | Target peripheral dividers |
| req_timed | input | 1 | 1 = timed settle instead of lock |
| pll_lock | input | 1 | PLL lock indication |
| mux_src | input | 1 | Mux acknowledge: source in use (1 = PLL) |
| volt_ack | input | 1 | Voltage mode currently in force |
| pll_mul | output | MUL_W | PLL multiplier setting |
| pll_div | output | DIV_W | PLL divider setting |
| pll_load | output | 1 | One-cycle PLL program strobe |
| clk_sel | output | 1 | Mux select (1 = PLL, 0 = safe) |
| ws | output | WS_W | Memory wait states |
| vmode | output | 1 | Voltage mode request |
| bus_pre | output | BUS_W | Bus prescaler |
| pdiv | output | NP*PW | Peripheral dividers |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Lock timeout flag |

## Verification
Two events can land on the same edge: the lock indication and the expiry of the lock timeout. The bench's PLL model raises lock a chosen number of cycles after the program strobe. Setting that delay to one cycle short of the window makes lock arrive exactly on the final timeout cycle, and setting it one cycle longer makes lock miss the window. In the first case the bench expects a clean completion with a `done` pulse and the new settings. In the second it expects `err`, the safe clock and the restored wait states, voltage mode and bus prescaler.

// File: rtl/clk_reseq_pkg.sv
package clk_reseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SAFE,
    S_LOCK,
    S_VUP,
    S_SELP,
    S_VDN,
    S_PERIPH
  } seq_state_e;
endpackage

// File: rtl/clk_reseq_ratio.sv
module clk_reseq_ratio #(
  parameter int MUL_W = 8,
  parameter int DIV_W = 4
) (
  input  logic [MUL_W-1:0] new_mul,
  input  logic [DIV_W-1:0] new_div,
  input  logic [MUL_W-1:0] cur_mul,
  input  logic [DIV_W-1:0] cur_div,
  output logic             going_up
);
  localparam int PROD_W = MUL_W + DIV_W;

  logic [PROD_W-1:0] new_scaled;
  logic [PROD_W-1:0] cur_scaled;

  // cross-multiply so no division is needed
  always_comb begin
    new_scaled = {{DIV_W{1'b0}}, new_mul} * {{MUL_W{1'b0}}, cur_div};
    cur_scaled = {{DIV_W{1'b0}}, cur_mul} * {{MUL_W{1'b0}}, new_div};
    going_up   = (new_scaled >= cur_scaled);
  end
endmodule

// File: rtl/clk_reseq_timer.sv
module clk_reseq_timer #(
  parameter int LOCK_TIME = 64,
  parameter int LOCK_TMO  = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic time_hit,
  output logic tmo_hit
);
  localparam int CW = $clog2(LOCK_TMO + 1);
  localparam logic [CW-1:0] TIME_LAST = CW'(LOCK_TIME - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(LOCK_TMO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != TMO_LAST) cnt <= cnt + 1'b1;
  end

  always_comb begin
    time_hit = (cnt >= TIME_LAST);
    tmo_hit  = (cnt == TMO_LAST);
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= TMO_LAST);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt != TMO_LAST) |=> (cnt == $past(cnt) + 1'b1) || $past(clr));
endmodule

// File: rtl/clk_reseq_pdiv.sv
module clk_reseq_pdiv #(
  parameter int PW = 8,
  parameter int NP = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic [NP*PW-1:0] d,
  output logic [NP*PW-1:0] q
);
  for (genvar i = 0; i < NP; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) q[i*PW +: PW] <= '0;
      else if (ld) q[i*PW +: PW] <= d[i*PW +: PW];
    end

    // R10
    ch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(q[i*PW +: PW]));
  end
endmodule

// File: rtl/clk_reseq_top.sv
module clk_reseq_top #(
  parameter int MUL_W     = 8,
  parameter int DIV_W     = 4,
  parameter int WS_W      = 4,
  parameter int BUS_W     = 3,
  parameter int PW        = 8,
  parameter int NP        = 3,
  parameter int LOCK_TIME = 64,
  parameter int LOCK_TMO  = 1024,
  parameter int RST_MUL   = 4,
  parameter int RST_DIV   = 1,
  parameter int RST_WS    = 1,
  parameter int RST_BUS   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [MUL_W-1:0]   req_mul,
  input  logic [DIV_W-1:0]   req_div,
  input  logic [WS_W-1:0]    req_ws,
  input  logic               req_vmode,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [NP*PW-1:0]   req_pdiv,
  input  logic               req_timed,
  input  logic               pll_lock,
  input  logic               mux_src,
  input  logic               volt_ack,
  output logic [MUL_W-1:0]   pll_mul,
  output logic [DIV_W-1:0]   pll_div,
  output logic               pll_load,
  output logic               clk_sel,
  output logic [WS_W-1:0]    ws,
  output logic               vmode,
  output logic [BUS_W-1:0]   bus_pre,
  output logic [NP*PW-1:0]   pdiv,
  output logic               busy,
  output logic               done,
  output logic               err
);
  import clk_reseq_pkg::*;

  seq_state_e state;

  logic [MUL_W-1:0] n_mul;
  logic [DIV_W-1:0] n_div;
  logic [WS_W-1:0]  n_ws;
  logic             n_vm;
  logic [BUS_W-1:0] n_bus;
  logic [NP*PW-1:0] n_pdiv;
  logic             timed_q;
  logic             up_q;
  logic [WS_W-1:0]  ws_old;
  logic             vm_old;
  logic [BUS_W-1:0] bus_old;

  logic ratio_up;
  logic time_hit;
  logic tmo_hit;
  logic timer_clr;
  logic pdiv_ld;
  logic accept;

  assign accept    = req_valid && !busy;
  assign timer_clr = (state != S_LOCK);
  assign pdiv_ld   = (state == S_PERIPH);

  clk_reseq_ratio #(.MUL_W(MUL_W), .DIV_W(DIV_W)) u_ratio (
    .new_mul (req_mul),
    .new_div (req_div),
    .cur_mul (pll_mul),
    .cur_div (pll_div),
    .going_up(ratio_up)
  );

  clk_reseq_timer #(.LOCK_TIME(LOCK_TIME), .LOCK_TMO(LOCK_TMO)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (timer_clr),
    .time_hit(time_hit),
    .tmo_hit (tmo_hit)
  );

  clk_reseq_pdiv #(.PW(PW), .NP(NP)) u_pdiv (
    .clk(clk),
    .rst(rst),
    .ld (pdiv_ld),
    .d  (n_pdiv),
    .q  (pdiv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      pll_mul <= MUL_W'(RST_MUL);
      pll_div <= DIV_W'(RST_DIV);
      pll_load <= 1'b0;
      clk_sel <= 1'b1;
      ws      <= WS_W'(RST_WS);
      vmode   <= 1'b0;
      bus_pre <= BUS_W'(RST_BUS);
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      n_mul   <= '0;
      n_div   <= '0;
      n_ws    <= '0;
      n_vm    <= 1'b0;
      n_bus   <= '0;
      n_pdiv  <= '0;
      timed_q <= 1'b0;
      up_q    <= 1'b0;
      ws_old  <= '0;
      vm_old  <= 1'b0;
      bus_old <= '0;
    end else begin
      pll_load <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            n_mul   <= req_mul;
            n_div   <= req_div;
            n_ws    <= req_ws;
            n_vm    <= req_vmode;
            n_bus   <= req_bus;
            n_pdiv  <= req_pdiv;
            timed_q <= req_timed;
            up_q    <= ratio_up;
            ws_old  <= ws;
            vm_old  <= vmode;
            bus_old <= bus_pre;
            // slowest of old and new bus divide while in transit
            bus_pre <= (req_bus > bus_pre) ? req_bus : bus_pre;
            clk_sel <= 1'b0;
            busy    <= 1'b1;
            err     <= 1'b0;
            state   <= S_SAFE;
          end
        end
        S_SAFE: begin
          if (!mux_src) begin
            pll_mul  <= n_mul;
            pll_div  <= n_div;
            pll_load <= 1'b1;
            state    <= S_LOCK;
          end
        end
        S_LOCK: begin
          if ((timed_q && time_hit) || (!timed_q && pll_lock)) begin
            if (up_q) begin
              ws    <= n_ws;
              vmode <= n_vm;
              state <= S_VUP;
            end else begin
              clk_sel <= 1'b1;
              state   <= S_SELP;
            end
          end else if (!timed_q && tmo_hit) begin
            ws      <= ws_old;
            vmode   <= vm_old;
            bus_pre <= bus_old;
            err     <= 1'b1;
            busy    <= 1'b0;
            state   <= S_IDLE;
          end
        end
        S_VUP: begin
          if (volt_ack == vmode) begin
            clk_sel <= 1'b1;
            state   <= S_SELP;
          end
        end
        S_SELP: begin
          if (mux_src) begin
            if (up_q) begin
              state <= S_PERIPH;
            end else begin
              ws    <= n_ws;
              vmode <= n_vm;
              state <= S_VDN;
            end
          end
        end
        S_VDN: begin
          if (volt_ack == vmode) state <= S_PERIPH;
        end
        S_PERIPH: begin
          bus_pre <= n_bus;
          busy    <= 1'b0;
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  load_on_safe_chk: assert property (@(posedge clk) disable iff (rst)
    pll_load |-> !clk_sel);

  // R8
  up_order_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_sel) && up_q) |-> (ws == n_ws && vmode == n_vm && volt_ack == vmode));

  // R9
  down_order_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_sel) && !up_q) |-> (ws == ws_old && vmode == vm_old));

  // R11
  bus_cap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bus_pre >= n_bus && bus_pre >= bus_old));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  err_safe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (!clk_sel && !busy));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && state != S_LOCK && state != S_PERIPH) |=> busy);
endmodule

// File: tb/tb_clk_reseq_top.sv
module tb_clk_reseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int MUL_W = 8, DIV_W = 4, WS_W = 4, BUS_W = 3, PW = 8, NP = 3;
  localparam int LOCK_TIME = 8, LOCK_TMO = 24;

  typedef struct packed {
    logic [7:0]  mul;
    logic [3:0]  div;
    logic [3:0]  ws;
    logic        vm;
    logic [2:0]  bus;
    logic [23:0] pd;
    logic        timed;
    logic [7:0]  lockd;
  } vec_t;

  // lockd: cycles from program strobe until lock; LOCK_TMO-1 is the last success
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd8,  4'd1, 4'd3, 1'b1, 3'd2, 24'h112233, 1'b0, 8'd5},
    '{8'd6,  4'd2, 4'd1, 1'b0, 3'd1, 24'h445566, 1'b0, 8'd3},
    '{8'd9,  4'd3, 4'd2, 1'b0, 3'd1, 24'h010203, 1'b1, 8'd255},
    '{8'd16, 4'd2, 4'd4, 1'b1, 3'd3, 24'h0a0b0c, 1'b0, 8'd40},
    '{8'd5,  4'd1, 4'd1, 1'b0, 3'd2, 24'h202020, 1'b0, 8'd23},
    '{8'd12, 4'd1, 4'd3, 1'b1, 3'd3, 24'h303030, 1'b0, 8'd24},
    '{8'd3,  4'd1, 4'd0, 1'b0, 3'd1, 24'h070707, 1'b0, 8'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [MUL_W-1:0] req_mul = '0;
  logic [DIV_W-1:0] req_div = '0;
  logic [WS_W-1:0]  req_ws = '0;
  logic             req_vmode = 1'b0;
  logic [BUS_W-1:0] req_bus = '0;
  logic [NP*PW-1:0] req_pdiv = '0;
  logic             req_timed = 1'b0;
  logic             pll_lock;
  logic             mux_src;
  logic             volt_ack;
  logic [MUL_W-1:0] pll_mul;
  logic [DIV_W-1:0] pll_div;
  logic             pll_load, clk_sel, vmode, busy, done, err;
  logic [WS_W-1:0]  ws;
  logic [BUS_W-1:0] bus_pre;
  logic [NP*PW-1:0] pdiv;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // environment models: mux 2 cycles, regulator 3 cycles, PLL lock after lockd
  logic [1:0] mux_d = 2'b11;
  logic [2:0] vol_d = 3'b000;
  int lc = 1000;
  int lockd_cur = 0;
  assign mux_src  = mux_d[1];
  assign volt_ack = vol_d[2];
  assign pll_lock = (lc >= lockd_cur);

  always @(negedge clk) begin
    mux_d <= {mux_d[0], clk_sel};
    vol_d <= {vol_d[1:0], vmode};
    if (pll_load) lc <= 0;
    else if (lc < 1000) lc <= lc + 1;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_reseq_top #(
    .MUL_W(MUL_W), .DIV_W(DIV_W), .WS_W(WS_W), .BUS_W(BUS_W), .PW(PW), .NP(NP),
    .LOCK_TIME(LOCK_TIME), .LOCK_TMO(LOCK_TMO),
    .RST_MUL(4), .RST_DIV(1), .RST_WS(1), .RST_BUS(1)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mul(req_mul), .req_div(req_div),
    .req_ws(req_ws), .req_vmode(req_vmode), .req_bus(req_bus), .req_pdiv(req_pdiv),
    .req_timed(req_timed), .pll_lock(pll_lock), .mux_src(mux_src), .volt_ack(volt_ack),
    .pll_mul(pll_mul), .pll_div(pll_div), .pll_load(pll_load), .clk_sel(clk_sel),
    .ws(ws), .vmode(vmode), .bus_pre(bus_pre), .pdiv(pdiv), .busy(busy), .done(done),
    .err(err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model of the programmed state
  int cm = 4, cd = 1;
  logic [WS_W-1:0]  ws_e = 1;
  logic             vm_e = 0;
  logic [BUS_W-1:0] bus_e = 1;
  logic [NP*PW-1:0] pd_e = '0;

  task automatic run(input vec_t v, input bit inject);
    bit up, ok_lock, saw_rise, bad3, bad10, bad11;
    logic [WS_W-1:0] rws; logic rvm, rva;
    logic [NP*PW-1:0] prev_pd;
    logic prev_sel;
    int n;
    up = (int'(v.mul) * cd >= cm * int'(v.div));
    ok_lock = v.timed || (int'(v.lockd) <= LOCK_TMO - 1);
    lockd_cur = v.lockd;
    saw_rise = 0; bad3 = 0; bad10 = 0; bad11 = 0; rws = '0; rvm = 0; rva = 0;
    @(negedge clk);
    req_mul = v.mul; req_div = v.div; req_ws = v.ws; req_vmode = v.vm;
    req_bus = v.bus; req_pdiv = v.pd; req_timed = v.timed; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !clk_sel && !err, "R2 R12 accept: busy, safe select, err cleared",
        {busy, clk_sel, err}, 3'b100);
    prev_sel = clk_sel; prev_pd = pdiv; n = 0;
    while (busy && n < 600) begin
      req_valid = 1'b0;
      if (pll_load && mux_src) bad3 = 1;
      if (pdiv != prev_pd && !mux_src) bad10 = 1;
      if (bus_pre < v.bus || bus_pre < bus_e) bad11 = 1;
      if (clk_sel && !prev_sel) begin
        saw_rise = 1; rws = ws; rvm = vmode; rva = volt_ack;
      end
      if (inject && n == 6) begin
        req_mul = 8'd2; req_div = 4'd1; req_ws = 4'd9; req_vmode = 1'b0;
        req_bus = 3'd7; req_pdiv = 24'hdeadbe; req_timed = 1'b1; req_valid = 1'b1;
      end
      prev_sel = clk_sel; prev_pd = pdiv;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(n < 600, "R13 sequence completes", n, 600);
    chk(!bad3, "R3 pll_load only on safe clock", bad3, 0);
    chk(!bad10, "R10 pdiv stable while on safe clock", bad10, 0);
    chk(!bad11, "R11 bus prescaler covers old and new during transit", bad11, 0);
    chk(pll_mul == v.mul && pll_div == v.div, "R3 PLL setting written",
        {pll_mul, pll_div}, {v.mul, v.div});
    cm = v.mul; cd = v.div;
    if (ok_lock) begin
      chk(done && !err, v.timed ? "R6 timed settle completes" : "R4 lock completes",
          {done, err}, 2'b10);
      if (up)
        chk(saw_rise && rws == v.ws && rvm == v.vm && rva == v.vm,
            "R7 R8 R13 up: ws/vmode raised and ack seen before select",
            {saw_rise, rws, rvm, rva}, {1'b1, v.ws, v.vm, v.vm});
      else
        chk(saw_rise && rws == ws_e && rvm == vm_e,
            "R7 R9 down: select returns before ws/vmode change",
            {saw_rise, rws, rvm}, {1'b1, ws_e, vm_e});
      ws_e = v.ws; vm_e = v.vm; bus_e = v.bus; pd_e = v.pd;
      chk(clk_sel && mux_src, "R13 back on PLL", {clk_sel, mux_src}, 2'b11);
    end else begin
      chk(err && !done && !clk_sel, "R5 timeout: err, no done, safe clock",
          {err, done, clk_sel}, 3'b100);
    end
    chk(ws == ws_e && vmode == vm_e, ok_lock ? "R8 R9 final ws/vmode" : "R5 ws/vmode restored",
        {ws, vmode}, {ws_e, vm_e});
    chk(bus_pre == bus_e, ok_lock ? "R11 final bus prescaler" : "R5 bus prescaler restored",
        bus_pre, bus_e);
    chk(pdiv == pd_e, "R10 peripheral dividers", pdiv, pd_e);
    @(negedge clk);
    chk(!done, "R12 done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(clk_sel && pll_mul == 4 && pll_div == 1 && ws == 1 && !vmode && bus_pre == 1 &&
        pdiv == '0 && !busy && !done && !err && !pll_load, "R1 reset state",
        {clk_sel, pll_mul, pll_div, ws, vmode, bus_pre, busy, done, err},
        {1'b1, 8'd4, 4'd1, 4'd1, 1'b0, 3'd1, 3'b000});
    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);
    // request arriving mid-sequence must be dropped
    run('{8'd10, 4'd1, 4'd2, 1'b1, 3'd2, 24'h0f0f0f, 1'b0, 8'd4}, 1'b1);
    chk(ws == 2 && pll_mul == 10 && pdiv == 24'h0f0f0f, "R2 request during busy ignored",
        {ws, pll_mul, pdiv}, {4'd2, 8'd10, 24'h0f0f0f});
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R2 no late start from dropped request", {busy, done}, 2'b00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL R13 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule